// File: doc/BRIEF.md
# Split-Port Transform Stage Buffer

This block stores sixteen 13-bit partial results between the two passes of a separable transform. Writing and reading are selected by separate indices, each with its own 4-to-16 row decoder. Each storage row therefore sees its own write-select line and its own read-select line, and one row can be loaded while a different row is read in the same cycle.

In a ping-pong schedule, one pass fills half of the rows with fresh results while the other pass drains the half written earlier, and the two halves swap roles on every pass. Writes take effect on the rising clock edge. The read word is a combinational function of the read index, and a port whose enable is low is cut off from the rows. When both indices name the same row in one cycle, the read sees the value held before the edge.

Top module: `xfrm_stage_buf`

## Requirements
- R1: While `rst_n` is low every row is cleared, so after reset each of the 16 rows reads back 0.
- R2: When `wr_en` is 1 at a rising clock edge, `wr_word` is stored in row `wr_idx` (rows numbered 0 to 15 by the 4-bit binary index). From the next cycle a read of that row returns it.
- R3: When `wr_en` is 0 at a rising clock edge, no row changes, whatever `wr_idx` and `wr_word` carry.
- R4: While `rd_en` is 1, `rd_word` equals the content of row `rd_idx` in the same cycle, with no clock edge in between.
- R5: While `rd_en` is 0, the read port is disconnected and `rd_word` is all zeros for any `rd_idx`.
- R6: A write to one row leaves the other 15 rows unchanged. A read of a different row in the same cycle returns that row's stored value.
- R7: When `wr_en` and `rd_en` are both 1 and `wr_idx` equals `rd_idx`, `rd_word` shows the old content in that cycle and the new word from the next cycle.
- R8: Ping-pong use works. Writing rows 0 to 7 while reading rows 8 to 15 in the same cycles, and then swapping the halves, returns on every read the word written to that row in the previous pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Active-low synchronous clear of all rows |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Row selected for writing |
| wr_word | input | 13 | Word to store |
| rd_en | input | 1 | Read port enable |
| rd_idx | input | 4 | Row selected for reading |
| rd_word | output | 13 | Content of the selected row, or zero when disabled |

## Verification
A write decoder that selects the wrong row, or more than one row, corrupts a row other than the target. The corruption shows at `rd_word` on the first later read of that row, and the full read sweeps after each phase reach every row within 16 cycles. A read decoder fault shows at once, because the read path is combinational and the bench samples `rd_word` in the same cycle it drives the index. An ordering fault in the same-row case shows as the new word appearing one cycle early.

// File: rtl/xfrm_buf_pkg.sv
package xfrm_buf_pkg;
  localparam int unsigned XB_DEPTH = 16;
  localparam int unsigned XB_WIDTH = 13;

  // Pass a word through when its select is high, else force zeros.
  function automatic logic [XB_WIDTH-1:0] gate_word(
    input logic [XB_WIDTH-1:0] w,
    input logic                s
  );
    return w & {XB_WIDTH{s}};
  endfunction
endpackage

// File: rtl/xfrm_row_dec.sv
module xfrm_row_dec #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [DEPTH-1:0] sel
);
  generate
    if (DEPTH == 16 && IDX_W == 4) begin : g_predec
      // Two 2-to-4 predecoders, then an AND plane per row.
      logic [3:0] lo_hot;
      logic [3:0] hi_hot;
      always_comb begin
        lo_hot = 4'b0000;
        hi_hot = 4'b0000;
        lo_hot[idx[1:0]] = 1'b1;
        hi_hot[idx[3:2]] = 1'b1;
      end
      for (genvar r = 0; r < 16; r++) begin : g_and
        assign sel[r] = en & hi_hot[r/4] & lo_hot[r%4];
      end
    end else begin : g_flat
      for (genvar r = 0; r < DEPTH; r++) begin : g_cmp
        assign sel[r] = en && (idx == IDX_W'(r));
      end
    end
  endgenerate
endmodule

// File: rtl/xfrm_buf_word.sv
module xfrm_buf_word #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/xfrm_read_mux.sv
module xfrm_read_mux #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 13
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] rows,
  input  logic [DEPTH-1:0]            sel,
  output logic [WIDTH-1:0]            word
);
  import xfrm_buf_pkg::*;
  always_comb begin
    word = '0;
    for (int r = 0; r < DEPTH; r++) begin
      word = word | (rows[r] & {WIDTH{sel[r]}});
    end
  end
endmodule

// File: rtl/xfrm_stage_buf.sv
module xfrm_stage_buf #(
  parameter int unsigned DEPTH = xfrm_buf_pkg::XB_DEPTH,
  parameter int unsigned WIDTH = xfrm_buf_pkg::XB_WIDTH,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_word
);
  // Per-row write-select and read-select lines, kept visible for checking.
  logic [DEPTH-1:0]            wr_row_sel;
  logic [DEPTH-1:0]            rd_row_sel;
  logic [DEPTH-1:0][WIDTH-1:0] row_q;

  xfrm_row_dec #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr_dec (
    .en(wr_en), .idx(wr_idx), .sel(wr_row_sel)
  );

  xfrm_row_dec #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rd_dec (
    .en(rd_en), .idx(rd_idx), .sel(rd_row_sel)
  );

  generate
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
      xfrm_buf_word #(.WIDTH(WIDTH)) u_word (
        .clk(clk), .rst_n(rst_n), .load(wr_row_sel[r]),
        .din(wr_word), .q(row_q[r])
      );
    end
  endgenerate

  xfrm_read_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd_mux (
    .rows(row_q), .sel(rd_row_sel), .word(rd_word)
  );
endmodule

// File: rtl/xfrm_stage_buf_chk.sv
module xfrm_stage_buf_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 13,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [WIDTH-1:0] wr_word,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_idx,
  input logic [WIDTH-1:0] rd_word,
  input logic [DEPTH-1:0] wr_row_sel,
  input logic [DEPTH-1:0] rd_row_sel
);
  // R2
  wr_sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_row_sel) == (wr_en ? 1 : 0));

  // R3
  wr_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_row_sel == '0);

  // R5
  rd_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_word == '0 && rd_row_sel == '0));

  // R4
  rd_sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_row_sel) && (rd_en == (rd_row_sel != '0)));

  // R2
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_en && rd_idx == $past(wr_idx)) |-> rd_word == $past(wr_word));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && rd_en && $past(rd_en) && rd_idx == $past(rd_idx))
      |-> rd_word == $past(rd_word));
endmodule

bind xfrm_stage_buf xfrm_stage_buf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_word(rd_word),
  .wr_row_sel(wr_row_sel), .rd_row_sel(rd_row_sel)
);

// File: tb/xfrm_stage_buf_tb.sv
module xfrm_stage_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [12:0] wr_word = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [12:0] rd_word;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [12:0] model [16];

  always #4 clk = ~clk;

  xfrm_stage_buf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  function automatic logic [12:0] pat(input int pass, input int i);
    return 13'((pass * 977 + i * 211 + 5) % 8192);
  endfunction

  // One cycle: drive at negedge, check the combinational read, then apply the edge.
  task automatic cyc(input logic we, input int wi, input logic [12:0] wd,
                     input logic re, input int ri, input string tag);
    logic [12:0] exp;
    @(negedge clk);
    wr_en = we; wr_idx = 4'(wi); wr_word = wd;
    rd_en = re; rd_idx = 4'(ri);
    #2;
    exp = re ? model[ri] : 13'h0;
    n_tests++;
    if (rd_word !== exp) begin
      n_fail++;
      $display("FAIL %s: row %0d rd_word=%h expected %h", tag, ri, rd_word, exp);
    end
    @(posedge clk);
    if (we) model[wi] = wd;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) cyc(1'b0, 0, 13'h0, 1'b1, i, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 13'h0;
    // Garbage on the write port during reset must not survive it.
    wr_en = 1'b1; wr_word = 13'h1ABC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; wr_en = 1'b0;
    sweep("R1");

    // R2: each row written then read back on the following cycle.
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, i, (i % 2 == 0) ? 13'h1FFF : pat(1, i), 1'b0, 0, "R5");
      cyc(1'b0, 0, 13'h0, 1'b1, i, "R2");
    end

    // R3: write enable low with busy data and index.
    for (int i = 0; i < 16; i++) cyc(1'b0, 15 - i, pat(9, i), 1'b1, i, "R3");
    sweep("R3");

    // R5: read port disabled at every index.
    for (int i = 0; i < 16; i++) cyc(1'b0, 0, 13'h0, 1'b0, i, "R5");

    // R6: walking one written to a single row, all others swept after.
    for (int k = 0; k < 16; k += 5) begin
      cyc(1'b1, k, 13'(1 << (k % 13)), 1'b1, (k + 7) % 16, "R6");
      sweep("R6");
    end

    // R7: same row written and read in one cycle, then read again.
    for (int i = 0; i < 16; i += 3) begin
      cyc(1'b1, i, pat(4, i) ^ 13'h0F0F, 1'b1, i, "R7");
      cyc(1'b0, 0, 13'h0, 1'b1, i, "R7");
    end

    // R8: ping-pong passes; writes to one half, reads from the other.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        if (p % 2 == 0) cyc(1'b1, i, pat(20 + p, i), 1'b1, i + 8, "R8");
        else            cyc(1'b1, i + 8, pat(20 + p, i + 8), 1'b1, i, "R8");
      end
    end
    sweep("R4");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule